// File: doc/BRIEF.md
# Grid-Cell Non-Maxima Suppression Unit

This unit consumes a raster-ordered stream of corner-response scores for one image (or one pyramid level of an image) and performs two reductions in a single pass. A score survives only when no other score inside the square window of side 2n+1 around it is strictly larger. The image is also partitioned into a regular grid of rectangular cells, and for every cell the strongest surviving non-zero score and its position are kept. One record per cell leaves the unit, so the number of features per frame is capped by the number of cells.

Scores are written into a ring of line buffers as they arrive. Once a line has all the lines it needs below it, the unit stops accepting input and scans that line, testing each pixel against its window and folding the survivors into one running best per cell column. At the end of a cell row the running bests are emitted in left-to-right order, each as score plus x-y location. The location is scaled by 2^k when the frame is pyramid level k, so every record lands on the full-resolution grid. Cell width at level k is (32·w)>>k and cell height is (h·2^(l-1))>>k, with l the number of levels in use.

Top module: `nmsgrid_top`

## Requirements
- R1: A score is a survivor only if it is non-zero and no position within Chebyshev distance cfgRadius (1 to 4) of it holds a strictly larger score; positions outside the image count as score zero, and equal neighbours do not suppress.
- R2: Each frame yields exactly ceil(W/cw)·ceil(H/ch) records, cw = (32·cfgCellMul)>>cfgLevel and ch = cfgCellRows<<(cfgLevels-1-cfgLevel), with partial cells at the right and bottom edges, in row-major cell order (left to right, then top to bottom).
- R3: A record carries the largest survivor score in its cell; on equal scores the one in the lowest column wins, and within that column the topmost row.
- R4: A cell holding no survivor produces a record with outScore 0.
- R5: outX and outY equal the winner's column and row in the level-local image multiplied by 2^cfgLevel.
- R6: outLast is 1 on the final record of a frame and 0 on every other record.
- R7: A pixel is taken only in a cycle with inValid and inReady both 1; inReady is 0 while lines are being scanned or records emitted, in particular in the cycle after the frame's last pixel is taken, and returns to 1 after the frame's last record.
- R8: During and right after reset, inReady is 1 and outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Score on inScore is offered |
| inReady | output | 1 | Unit can take a score this cycle |
| inScore | input | 8 | Corner response, raster order |
| cfgWidth | input | 7 | Image width in pixels, 1 to 64 |
| cfgHeight | input | 7 | Image height in lines, 1 to 64 |
| cfgRadius | input | 3 | Window radius n, 1 to 4 |
| cfgCellMul | input | 3 | Cell width multiplier w (level-0 width 32·w) |
| cfgCellRows | input | 4 | Cell height factor h |
| cfgLevels | input | 3 | Number of pyramid levels l, 1 to 4 |
| cfgLevel | input | 2 | Level k of this frame, below cfgLevels |
| outValid | output | 1 | A cell record is present this cycle |
| outScore | output | 8 | Winning score, 0 for an empty cell |
| outX | output | 9 | Winner column scaled to level 0 |
| outY | output | 9 | Winner row scaled to level 0 |
| outLast | output | 1 | Record is the last of the frame |

## Verification
The hardest situations to reach are ties that cross lines and lanes: equal scores spread over several rows and columns of one cell, where both the non-strict window test and the column-then-row tie rule decide the outcome. The bench drives low-range random images (values 0 to 3) and a flat image so that plateaus are everywhere, together with frames shorter than the radius, partial edge cells and the smallest four-pixel cells at level 3, and compares every record against a model computed from the requirements.

// File: rtl/nmsgrid_pkg.sv
package nmsgrid_pkg;
  localparam int MAX_W      = 64;
  localparam int MAX_H      = 64;
  localparam int MAX_R      = 4;
  localparam int SCORE_W    = 8;
  localparam int MAX_LVL    = 4;
  localparam int NLINES     = 2 * MAX_R + 1;
  localparam int XW         = $clog2(MAX_W);
  localparam int YW         = $clog2(MAX_H);
  localparam int LW         = $clog2(MAX_LVL);
  localparam int SLOTW      = $clog2(NLINES);
  localparam int MIN_CELL_W = 32 >> (MAX_LVL - 1);
  localparam int NCX        = (MAX_W + MIN_CELL_W - 1) / MIN_CELL_W;
  localparam int CXW        = $clog2(NCX);
  localparam int OXW        = XW + MAX_LVL - 1;
  localparam int OYW        = YW + MAX_LVL - 1;

  typedef enum logic [1:0] {S_RECV, S_EVAL, S_EMIT} nms_state_t;

  typedef struct packed {
    logic             wr;
    logic [SLOTW-1:0] wrSlot;
    logic [XW-1:0]    wrX;
    logic             ev;
    logic [SLOTW-1:0] evSlot;
    logic [XW-1:0]    evX;
    logic [YW-1:0]    evY;
    logic [CXW-1:0]   evCell;
    logic             emit;
    logic [CXW-1:0]   emitCell;
    logic             emitLast;
  } nms_strobe_t;
endpackage

// File: rtl/nmsgrid_ctrl.sv
module nmsgrid_ctrl
  import nmsgrid_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic [XW:0]   cfgWidth,
  input  logic [YW:0]   cfgHeight,
  input  logic [2:0]    cfgRadius,
  input  logic [2:0]    cfgCellMul,
  input  logic [3:0]    cfgCellRows,
  input  logic [2:0]    cfgLevels,
  input  logic [LW-1:0] cfgLevel,
  output nms_strobe_t   st
);
  nms_state_t       state;
  logic [XW-1:0]    rx, ex;
  logic [YW-1:0]    ry, ey;
  logic [SLOTW-1:0] wrSlot, evSlot;
  logic [7:0]       exIn;
  logic [6:0]       eyIn;
  logic [CXW-1:0]   exCell, emitCell, lastCx;
  logic             frameIn;

  logic [7:0]    cellW;
  logic [6:0]    cellH;
  logic [2:0]    shiftH;
  logic [XW-1:0] wLast;
  logic [YW-1:0] hLast;
  logic          accept, rowEnd, newFrame;
  nms_state_t    advState;

  function automatic logic [SLOTW-1:0] slotInc(input logic [SLOTW-1:0] s);
    return (int'(s) == NLINES - 1) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    cellW    = {cfgCellMul, 5'b0} >> cfgLevel;
    shiftH   = cfgLevels - 3'd1 - {1'b0, cfgLevel};
    cellH    = 7'({3'b0, cfgCellRows} << shiftH);
    wLast    = XW'(cfgWidth - 1'b1);
    hLast    = YW'(cfgHeight - 1'b1);
    accept   = inValid && (state == S_RECV);
    rowEnd   = (eyIn == cellH - 7'd1) || (ey == hLast);
    newFrame = frameIn && (ey == hLast);
    advState = (frameIn && !newFrame) ? S_EVAL : S_RECV;
    inReady  = (state == S_RECV);
  end

  always_comb begin
    st.wr       = accept;
    st.wrSlot   = wrSlot;
    st.wrX      = rx;
    st.ev       = (state == S_EVAL);
    st.evSlot   = evSlot;
    st.evX      = ex;
    st.evY      = ey;
    st.evCell   = exCell;
    st.emit     = (state == S_EMIT);
    st.emitCell = emitCell;
    st.emitLast = (emitCell == lastCx) && (ey == hLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_RECV; rx <= '0; ry <= '0; ex <= '0; ey <= '0;
      wrSlot <= '0; evSlot <= '0; exIn <= '0; eyIn <= '0;
      exCell <= '0; emitCell <= '0; lastCx <= '0; frameIn <= 1'b0;
    end else begin
      case (state)
        S_RECV: if (accept) begin
          if (rx == wLast) begin
            rx     <= '0;
            wrSlot <= slotInc(wrSlot);
            if (ry == hLast) begin
              ry <= '0; frameIn <= 1'b1; state <= S_EVAL;
            end else begin
              ry <= ry + 1'b1;
              if (ry >= YW'(cfgRadius)) state <= S_EVAL;
            end
          end else rx <= rx + 1'b1;
        end
        S_EVAL: begin
          if (ex == wLast) begin
            ex <= '0; exIn <= '0; exCell <= '0; lastCx <= exCell;
            if (rowEnd) begin
              eyIn <= '0; emitCell <= '0; state <= S_EMIT;
            end else begin
              eyIn   <= eyIn + 1'b1;
              ey     <= newFrame ? '0 : ey + 1'b1;
              evSlot <= newFrame ? '0 : slotInc(evSlot);
              state  <= advState;
            end
          end else begin
            ex <= ex + 1'b1;
            if (exIn == cellW - 8'd1) begin
              exIn <= '0; exCell <= exCell + 1'b1;
            end else exIn <= exIn + 1'b1;
          end
        end
        default: begin
          if (emitCell == lastCx) begin
            ey     <= newFrame ? '0 : ey + 1'b1;
            evSlot <= newFrame ? '0 : slotInc(evSlot);
            state  <= advState;
            if (newFrame) begin
              frameIn <= 1'b0; wrSlot <= '0;
            end
          end else emitCell <= emitCell + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nmsgrid_path.sv
module nmsgrid_path
  import nmsgrid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SCORE_W-1:0] inScore,
  input  logic [XW:0]        cfgWidth,
  input  logic [YW:0]        cfgHeight,
  input  logic [2:0]         cfgRadius,
  input  logic [LW-1:0]      cfgLevel,
  input  nms_strobe_t        st,
  output logic               outValid,
  output logic [SCORE_W-1:0] outScore,
  output logic [OXW-1:0]     outX,
  output logic [OYW-1:0]     outY,
  output logic               outLast
);
  localparam int NWIN = NLINES * NLINES;

  logic [SCORE_W-1:0] lineBuf [NLINES][MAX_W];
  logic [SCORE_W-1:0] center;
  logic [NWIN-1:0]    beats;
  logic               survive, better;

  logic [SCORE_W-1:0] accS [NCX];
  logic [XW-1:0]      accX [NCX];
  logic [YW-1:0]      accY [NCX];

  always_ff @(posedge clk) begin
    if (st.wr) lineBuf[st.wrSlot][st.wrX] <= inScore;
  end

  assign center = lineBuf[st.evSlot][st.evX];

  for (genvar gy = 0; gy < NLINES; gy++) begin : g_row
    for (genvar gx = 0; gx < NLINES; gx++) begin : g_col
      localparam int DY  = gy - MAX_R;
      localparam int DX  = gx - MAX_R;
      localparam int ADY = (DY < 0) ? -DY : DY;
      localparam int ADX = (DX < 0) ? -DX : DX;
      int   rowI, colI, slotI;
      logic inWin;
      always_comb begin
        rowI  = int'(st.evY) + DY;
        colI  = int'(st.evX) + DX;
        slotI = int'(st.evSlot) + DY;
        if (slotI < 0) slotI = slotI + NLINES;
        else if (slotI >= NLINES) slotI = slotI - NLINES;
        inWin = (ADY <= int'(cfgRadius)) && (ADX <= int'(cfgRadius)) &&
                (rowI >= 0) && (rowI < int'(cfgHeight)) &&
                (colI >= 0) && (colI < int'(cfgWidth));
      end
      assign beats[gy*NLINES+gx] =
        inWin && (lineBuf[SLOTW'(slotI)][XW'(colI)] > center);
    end
  end

  assign survive = st.ev && (center != '0) && (beats == '0);
  assign better  = (center > accS[st.evCell]) ||
                   ((center == accS[st.evCell]) && (st.evX < accX[st.evCell]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCX; i++) accS[i] <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outScore <= '0;
      outX     <= '0;
      outY     <= '0;
    end else begin
      outValid <= st.emit;
      outLast  <= st.emit && st.emitLast;
      if (survive && better) begin
        accS[st.evCell] <= center;
        accX[st.evCell] <= st.evX;
        accY[st.evCell] <= st.evY;
      end
      if (st.emit) begin
        outScore <= accS[st.emitCell];
        outX     <= OXW'(accX[st.emitCell]) << cfgLevel;
        outY     <= OYW'(accY[st.emitCell]) << cfgLevel;
        accS[st.emitCell] <= '0;
      end
    end
  end
endmodule

// File: rtl/nmsgrid_top.sv
module nmsgrid_top
  import nmsgrid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [SCORE_W-1:0] inScore,
  input  logic [XW:0]        cfgWidth,
  input  logic [YW:0]        cfgHeight,
  input  logic [2:0]         cfgRadius,
  input  logic [2:0]         cfgCellMul,
  input  logic [3:0]         cfgCellRows,
  input  logic [2:0]         cfgLevels,
  input  logic [LW-1:0]      cfgLevel,
  output logic               outValid,
  output logic [SCORE_W-1:0] outScore,
  output logic [OXW-1:0]     outX,
  output logic [OYW-1:0]     outY,
  output logic               outLast
);
  nms_strobe_t st;

  nmsgrid_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgRadius(cfgRadius),
    .cfgCellMul(cfgCellMul), .cfgCellRows(cfgCellRows),
    .cfgLevels(cfgLevels), .cfgLevel(cfgLevel), .st(st)
  );

  nmsgrid_path u_path (
    .clk(clk), .rstN(rstN), .inScore(inScore), .cfgWidth(cfgWidth),
    .cfgHeight(cfgHeight), .cfgRadius(cfgRadius), .cfgLevel(cfgLevel),
    .st(st), .outValid(outValid), .outScore(outScore), .outX(outX),
    .outY(outY), .outLast(outLast)
  );
endmodule

// File: rtl/nmsgrid_chk.sv
module nmsgrid_chk
  import nmsgrid_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inReady,
  input logic [XW:0]        cfgWidth,
  input logic [YW:0]        cfgHeight,
  input logic [LW-1:0]      cfgLevel,
  input logic               outValid,
  input logic [SCORE_W-1:0] outScore,
  input logic [OXW-1:0]     outX,
  input logic [OYW-1:0]     outY,
  input logic               outLast
);
  // R6: the frame-end flag only travels with a record
  p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R5: a real winner's location is a multiple of the level scale
  p_x_scaled_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outScore != '0) |-> ((int'(outX) % (1 << cfgLevel)) == 0));
  p_y_scaled_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outScore != '0) |-> ((int'(outY) % (1 << cfgLevel)) == 0));

  // R2: a winner lies inside the image once scaled
  p_inside_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outScore != '0) |->
      ((int'(outX) < (int'(cfgWidth) << cfgLevel)) &&
       (int'(outY) < (int'(cfgHeight) << cfgLevel))));

  // R7: a burst of records starts only after input was closed
  p_emit_after_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(!inReady));

  // R7: input reopens together with the last record
  p_reopen_at_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> inReady);
endmodule

bind nmsgrid_top nmsgrid_chk u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .cfgWidth(cfgWidth),
  .cfgHeight(cfgHeight), .cfgLevel(cfgLevel), .outValid(outValid),
  .outScore(outScore), .outX(outX), .outY(outY), .outLast(outLast)
);

// File: tb/tb_nmsgrid_top.sv
module tb_nmsgrid_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXREC = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inScore = '0;
  logic [6:0] cfgWidth = 7'd64;
  logic [6:0] cfgHeight = 7'd8;
  logic [2:0] cfgRadius = 3'd1;
  logic [2:0] cfgCellMul = 3'd1;
  logic [3:0] cfgCellRows = 4'd1;
  logic [2:0] cfgLevels = 3'd1;
  logic [1:0] cfgLevel = 2'd0;
  logic       outValid, outLast;
  logic [7:0] outScore;
  logic [8:0] outX, outY;

  nmsgrid_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inScore(inScore), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgRadius(cfgRadius), .cfgCellMul(cfgCellMul), .cfgCellRows(cfgCellRows),
    .cfgLevels(cfgLevels), .cfgLevel(cfgLevel), .outValid(outValid),
    .outScore(outScore), .outX(outX), .outY(outY), .outLast(outLast)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int unsigned lcg = 32'h1234_5678;

  int img [64][64];
  int expS [MAXREC];
  int expX [MAXREC];
  int expY [MAXREC];
  int gotS [MAXREC];
  int gotX [MAXREC];
  int gotY [MAXREC];
  int gotL [MAXREC];
  int gotN = 0;

  function automatic int rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg >> 8);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN && outValid && gotN < MAXREC) begin
      gotS[gotN] = int'(outScore);
      gotX[gotN] = int'(outX);
      gotY[gotN] = int'(outY);
      gotL[gotN] = int'(outLast);
      gotN = gotN + 1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic bit survives(int x, int y, int w, int h, int r);
    if (img[y][x] == 0) return 1'b0;
    for (int dy = -r; dy <= r; dy++)
      for (int dx = -r; dx <= r; dx++)
        if (y+dy >= 0 && y+dy < h && x+dx >= 0 && x+dx < w)
          if (img[y+dy][x+dx] > img[y][x]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic runFrame(input int w, input int h, input int r, input int cm,
                          input int cr, input int lv, input int k, input int pat);
    int cw, ch, ncx, ncy, n, base, waited;
    bit acc;
    // build image
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        case (pat)
          0: img[y][x] = rnd() % 256;
          1: img[y][x] = rnd() % 4;
          2: img[y][x] = 5;
          default: img[y][x] = 0;
        endcase
      end
    // expected records
    cw = (32 * cm) >> k;
    ch = cr << (lv - 1 - k);
    ncx = (w + cw - 1) / cw;
    ncy = (h + ch - 1) / ch;
    n = 0;
    for (int cy = 0; cy < ncy; cy++)
      for (int cx = 0; cx < ncx; cx++) begin
        int best, bx, by;
        best = 0; bx = 0; by = 0;
        for (int x = cx*cw; x < (cx+1)*cw && x < w; x++)
          for (int y = cy*ch; y < (cy+1)*ch && y < h; y++)
            if (survives(x, y, w, h, r) && img[y][x] > best) begin
              best = img[y][x]; bx = x; by = y;
            end
        expS[n] = best; expX[n] = bx << k; expY[n] = by << k;
        n = n + 1;
      end
    // configure and reset
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0;
    cfgWidth = 7'(w); cfgHeight = 7'(h); cfgRadius = 3'(r);
    cfgCellMul = 3'(cm); cfgCellRows = 4'(cr); cfgLevels = 3'(lv); cfgLevel = 2'(k);
    repeat (2) @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R8 reset state ready/valid", int'({inReady, outValid}), 2);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R8 after reset ready/valid", int'({inReady, outValid}), 2);
    base = gotN;
    // stream pixels with gaps
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        acc = 1'b0;
        waited = 0;
        while (!acc && waited < 5000) begin
          @(negedge clk);
          inValid = (rnd() % 5) != 0;
          inScore = 8'(img[y][x]);
          #1;
          acc = inValid && inReady;
          waited = waited + 1;
        end
      end
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check(inReady == 1'b0, "R7 ready low after final pixel", int'(inReady), 0);
    waited = 0;
    while (gotN - base < n && waited < 20000) begin
      @(negedge clk);
      waited = waited + 1;
    end
    repeat (20) @(negedge clk);
    check(gotN - base == n, "R2 record count", gotN - base, n);
    check(inReady == 1'b1, "R7 ready back after frame", int'(inReady), 1);
    for (int i = 0; i < n && base + i < gotN; i++) begin
      if (expS[i] == 0)
        check(gotS[base+i] == 0, "R4 empty cell score", gotS[base+i], 0);
      else begin
        check(gotS[base+i] == expS[i], "R1 R3 cell score", gotS[base+i], expS[i]);
        check(gotX[base+i] == expX[i], "R3 R5 winner x", gotX[base+i], expX[i]);
        check(gotY[base+i] == expY[i], "R3 R5 winner y", gotY[base+i], expY[i]);
      end
      check(gotL[base+i] == int'(i == n - 1), "R6 last flag", gotL[base+i], int'(i == n - 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    runFrame(64, 16, 1, 1, 4, 1, 0, 0);  // R1 R2 base grid, radius 1
    runFrame(40,  7, 2, 1, 2, 2, 1, 1);  // R3 ties, partial cells, level 1
    runFrame(64, 10, 4, 2, 3, 1, 0, 0);  // R1 widest radius, wide cell
    runFrame(20,  6, 3, 1, 1, 4, 3, 1);  // R5 scale by 8, 4-pixel cells
    runFrame(33,  5, 2, 1, 2, 1, 0, 2);  // R3 flat plateau tie rule
    runFrame(48,  9, 1, 1, 4, 2, 1, 3);  // R4 empty image
    runFrame(64,  2, 4, 1, 1, 1, 0, 0);  // R1 frame shorter than radius
    runFrame(37, 13, 3, 1, 5, 3, 2, 1);  // R2 R5 level 2, odd sizes
    runFrame(64, 16, 2, 1, 4, 1, 0, 0);  // R7 back-to-back frame
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule